// File: doc/BRIEF.md
# SPI Master/Slave Port with Mode-Fault Detection

This block is a byte-wide serial peripheral port. A control bit selects its role. As a master it starts a transfer when software writes the data register. It then generates SCK from a programmable baud divider, shifts the byte out MSB first on MOSI in SPI mode 0 and captures MISO. It can also drive a slave-select line that is low for the whole byte. As a slave it follows an external SCK while the slave-select input is low. It returns its preloaded byte on MISO and collects the byte arriving on MOSI.

Software reaches the port through a small register bus with five registers: control, baud, status, data and pin direction. Each pin has a separate output value and output enable, so the pad ring can build the tri-state pads. The mode-fault detector watches the slave-select input while the port is an enabled master with that pin set as an input. A low on it means another master is on the bus. The port then stops driving the bus at once, drops out of master operation and flags the event. The interrupt line goes high for a finished byte or for a fault when interrupts are enabled.

Top module: `spi_port`

## Requirements
- R1: After reset every register reads 0x00, all four output enables are low, `ss_o` is high and `irq` is low.
- R2: Register 1 holds the rate select in bits 2:0 and the prescale select in bits 6:4. One SCK half period lasts (prescale+1)·2^rate clocks. The first SCK rising edge comes exactly one half period after the clock edge that accepts the data write.
- R3: A master transfer sends eight SCK pulses with SCK idling low. MOSI carries the byte MSB first and changes only on falling SCK edges. MISO is sampled on rising edges. Once the transfer ends, the received byte reads back from register 3.
- R4: A write to the data register while a master transfer is in progress is ignored. It changes neither the byte being sent nor the received byte, and it starts no second transfer.
- R5: Control register 0 uses bit 0 as enable and bit 1 as master select. Direction register 4 uses bit 0 for SCK, bit 1 for MOSI, bit 2 for MISO and bit 3 for slave-select. In master mode an output enable is high only when its direction bit is set. `ss_o` is low for the whole transfer and high while idle.
- R6: Status bit 7 sets when a byte completes. It clears only when a status read that sees it set is followed by a read or write of the data register. With control bit 2 (interrupt enable) set, `irq` is high while the flag is set.
- R7: Mode fault occurs when the port is an enabled master, direction bit 3 is clear and `ss_i` is low, after a two-stage synchronizer. The port then sets status bit 4, clears the enable and master bits, clears direction bits 2:0, aborts the transfer and drops the SCK and MOSI enables. With interrupts enabled, `irq` rises.
- R8: The fault flag clears only when a status read that sees it set is followed by a write to the control register. A control write with no such status read before it leaves the flag set.
- R9: In slave mode, with `ss_i` low, the port samples `mosi_i` on rising `sck_i` edges and shifts on falling edges. After eight bits the byte is readable in register 3 and status bit 7 sets.
- R10: In slave mode, after a data write loads the shift register, MISO gives that byte MSB first. `miso_oe` is high only while the synchronized `ss_i` is low and direction bit 2 is set. A high `ss_i` releases MISO and resets the bit count, so a partial byte is discarded.
- R11: In slave mode a data write starts no transfer: SCK stays low, `ss_o` stays high and status bit 7 stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 3 | Register select: 0 control, 1 baud, 2 status, 3 data, 4 direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock generated as master |
| sck_oe | output | 1 | Drive enable for SCK |
| mosi_i | input | 1 | Serial data in when slave |
| mosi_o | output | 1 | Serial data out when master |
| mosi_oe | output | 1 | Drive enable for MOSI |
| miso_i | input | 1 | Serial data in when master |
| miso_o | output | 1 | Serial data out when slave |
| miso_oe | output | 1 | Drive enable for MISO |
| ss_i | input | 1 | Slave-select input (select when slave, fault sense when master) |
| ss_o | output | 1 | Slave-select driven as master |
| ss_oe | output | 1 | Drive enable for slave-select |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit counter or a wrong baud count shows at the pins within one byte time. SCK pulses appear in the wrong number, or the first rising edge arrives off the half-period count. A shift register that loads or shifts at the wrong moment shows up as a wrong MOSI bit at the next rising SCK edge, and as a wrong byte when the data register is read. A stuck fault or flag-clearing state shows within three clocks of a low slave-select: an output enable stays high, `irq` disagrees with the interrupt bit, or the control register reads back wrong.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    // register selects on the bus
    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_BAUD = 3'd1,
        REG_STAT = 3'd2,
        REG_DATA = 3'd3,
        REG_DIR  = 3'd4
    } reg_sel_e;

    // control register fields
    localparam int unsigned CTL_EN = 0;
    localparam int unsigned CTL_MS = 1;
    localparam int unsigned CTL_IE = 2;

    // baud register: rate select at bit 0, prescale select from this bit
    localparam int unsigned PRE_LSB = 4;

    // status register fields
    localparam int unsigned STA_DONE = 7;
    localparam int unsigned STA_FLT  = 4;

    // direction register fields
    localparam int unsigned DIR_W    = 4;
    localparam int unsigned DIR_SCK  = 0;
    localparam int unsigned DIR_MOSI = 1;
    localparam int unsigned DIR_MISO = 2;
    localparam int unsigned DIR_SS   = 3;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_q;
    logic [STAGES-1:0][W-1:0] stage_d;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
    parameter int unsigned RATE_W = 3,
    parameter int unsigned PRE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    input  logic [PRE_W-1:0]  pre,
    output logic              tick
);
    localparam int unsigned RATE_MAX = (1 << RATE_W) - 1;
    localparam int unsigned CNT_W    = PRE_W + RATE_MAX + 1;

    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        half_len = (CNT_W'(pre) + CNT_W'(1)) << rate;
        tick     = run && (cnt_q == half_len - CNT_W'(1));
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_act,
    input  logic              s_act,
    input  logic              start,
    input  logic              load,
    input  logic              abort,
    input  logic              tick,
    input  logic [DATA_W-1:0] load_data,
    input  logic              m_miso,
    input  logic              s_sck,
    input  logic              s_ss,
    input  logic              s_mosi,
    output logic              busy,
    output logic              sck,
    output logic              tx_bit,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic              busy;
        logic              sck;
        logic              samp;
        logic              sck_prev;
        logic              done;
        logic [CNT_W-1:0]  nbits;
        logic [DATA_W-1:0] shreg;
    } sh_st_t;

    sh_st_t q, d;
    logic   s_rise, s_fall;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.sck_prev = s_sck;
        s_rise     = s_sck & ~q.sck_prev;
        s_fall     = ~s_sck & q.sck_prev;

        if (abort) begin
            d.busy  = 1'b0;
            d.sck   = 1'b0;
            d.nbits = '0;
        end else if (m_act) begin
            if (!q.busy) begin
                if (start) begin
                    d.busy  = 1'b1;
                    d.sck   = 1'b0;
                    d.nbits = '0;
                    d.shreg = load_data;
                end
            end else if (tick) begin
                if (!q.sck) begin
                    d.sck  = 1'b1;
                    d.samp = m_miso;
                end else begin
                    d.sck   = 1'b0;
                    d.shreg = {q.shreg[DATA_W-2:0], q.samp};
                    d.nbits = q.nbits + CNT_W'(1);
                    if (q.nbits == LAST) begin
                        d.busy  = 1'b0;
                        d.done  = 1'b1;
                        d.nbits = '0;
                    end
                end
            end
        end else if (s_act) begin
            d.busy = 1'b0;
            d.sck  = 1'b0;
            if (s_ss) begin
                d.nbits = '0;
            end else begin
                if (s_rise) d.samp = s_mosi;
                if (s_fall) begin
                    d.shreg = {q.shreg[DATA_W-2:0], q.samp};
                    d.nbits = q.nbits + CNT_W'(1);
                    if (q.nbits == LAST) begin
                        d.done  = 1'b1;
                        d.nbits = '0;
                    end
                end
            end
            if (load && (q.nbits == '0) && !(s_fall && !s_ss)) d.shreg = load_data;
        end else begin
            d.busy  = 1'b0;
            d.sck   = 1'b0;
            d.nbits = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign sck     = q.sck;
    assign tx_bit  = q.shreg[DATA_W-1];
    assign done    = q.done;
    assign rx_data = q.shreg;
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned RATE_W      = 3,
    parameter int unsigned PRE_W       = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_i,
    output logic              ss_o,
    output logic              ss_oe,
    output logic              irq
);
    typedef struct packed {
        logic              en;
        logic              ms;
        logic              ie;
        logic [RATE_W-1:0] rate;
        logic [PRE_W-1:0]  pre;
        logic [DIR_W-1:0]  dir;
        logic              done_f;
        logic              flt_f;
        logic              arm_done;
        logic              arm_flt;
        logic [DATA_W-1:0] rx;
    } port_st_t;

    port_st_t q, d;

    logic [2:0]        sync_vec;
    logic              ss_s, sck_s, mosi_s;
    logic              m_act, s_act, fault_hit;
    logic              rd_stat, data_acc;
    logic              sh_start, sh_load, sh_abort;
    logic              sh_busy, sh_sck, sh_tx, sh_done;
    logic [DATA_W-1:0] sh_rx;
    logic              tick;

    // pin inputs: slave-select resets high, clock and data low
    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ss_i, sck_i, mosi_i}),
        .dout (sync_vec)
    );
    assign ss_s   = sync_vec[2];
    assign sck_s  = sync_vec[1];
    assign mosi_s = sync_vec[0];

    assign m_act     = q.en & q.ms;
    assign s_act     = q.en & ~q.ms;
    assign fault_hit = m_act & ~q.dir[DIR_SS] & ~ss_s;

    spi_baud #(.RATE_W(RATE_W), .PRE_W(PRE_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (sh_busy & m_act),
        .rate (q.rate),
        .pre  (q.pre),
        .tick (tick)
    );

    spi_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .m_act    (m_act),
        .s_act    (s_act),
        .start    (sh_start),
        .load     (sh_load),
        .abort    (sh_abort),
        .tick     (tick),
        .load_data(bus_wdata),
        .m_miso   (miso_i),
        .s_sck    (sck_s),
        .s_ss     (ss_s),
        .s_mosi   (mosi_s),
        .busy     (sh_busy),
        .sck      (sh_sck),
        .tx_bit   (sh_tx),
        .done     (sh_done),
        .rx_data  (sh_rx)
    );

    always_comb begin
        d        = q;
        sh_start = 1'b0;
        sh_load  = 1'b0;
        sh_abort = 1'b0;
        rd_stat  = bus_rd && (bus_addr == REG_STAT);
        data_acc = (bus_rd || bus_wr) && (bus_addr == REG_DATA);

        // a status read arms the clearing of whatever flags it saw set
        if (rd_stat) begin
            d.arm_done = q.done_f;
            d.arm_flt  = q.flt_f;
        end

        if (bus_wr) begin
            case (bus_addr)
                REG_CTRL: begin
                    d.en = bus_wdata[CTL_EN];
                    d.ms = bus_wdata[CTL_MS];
                    d.ie = bus_wdata[CTL_IE];
                    if (q.arm_flt) begin
                        d.flt_f   = 1'b0;
                        d.arm_flt = 1'b0;
                    end
                end
                REG_BAUD: begin
                    d.rate = bus_wdata[RATE_W-1:0];
                    d.pre  = bus_wdata[PRE_LSB +: PRE_W];
                end
                REG_DIR:  d.dir = bus_wdata[DIR_W-1:0];
                REG_DATA: begin
                    if (m_act && !sh_busy) sh_start = 1'b1;
                    else if (s_act)        sh_load  = 1'b1;
                end
                default: ;
            endcase
        end

        if (data_acc && q.arm_done) begin
            d.done_f   = 1'b0;
            d.arm_done = 1'b0;
        end

        if (sh_done) begin
            d.done_f = 1'b1;
            d.rx     = sh_rx;
        end

        if (fault_hit) begin
            d.flt_f         = 1'b1;
            d.en            = 1'b0;
            d.ms            = 1'b0;
            d.dir[DIR_SCK]  = 1'b0;
            d.dir[DIR_MOSI] = 1'b0;
            d.dir[DIR_MISO] = 1'b0;
            sh_abort        = 1'b1;
            sh_start        = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: begin
                bus_rdata[CTL_EN] = q.en;
                bus_rdata[CTL_MS] = q.ms;
                bus_rdata[CTL_IE] = q.ie;
            end
            REG_BAUD: begin
                bus_rdata[RATE_W-1:0]       = q.rate;
                bus_rdata[PRE_LSB +: PRE_W] = q.pre;
            end
            REG_STAT: begin
                bus_rdata[STA_DONE] = q.done_f;
                bus_rdata[STA_FLT]  = q.flt_f;
            end
            REG_DATA: bus_rdata = q.rx;
            REG_DIR:  bus_rdata[DIR_W-1:0] = q.dir;
            default:  ;
        endcase
    end

    assign sck_o   = sh_sck;
    assign sck_oe  = m_act & q.dir[DIR_SCK];
    assign mosi_o  = sh_tx;
    assign mosi_oe = m_act & q.dir[DIR_MOSI];
    assign miso_o  = sh_tx;
    assign miso_oe = s_act & q.dir[DIR_MISO] & ~ss_s;
    assign ss_o    = ~sh_busy;
    assign ss_oe   = m_act & q.dir[DIR_SS];
    assign irq     = q.ie & (q.done_f | q.flt_f);
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic clk,
    input logic rst_n,
    input logic m_act,
    input logic busy,
    input logic fault_hit,
    input logic sck_o,
    input logic mosi_o,
    input logic sck_oe,
    input logic mosi_oe,
    input logic miso_oe,
    input logic ss_o,
    input logic ss_oe,
    input logic ss_i
);
    AST_FAULT_RELEASES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit |=> (!sck_oe && !mosi_oe && !miso_oe)); // R7

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_o); // R3

    AST_MOSI_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (m_act && busy && $past(busy) && !$fell(sck_o)) |-> $stable(mosi_o)); // R3

    AST_SS_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_oe && $fell(ss_o)) |-> !sck_o); // R5

    AST_MISO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ss_i) && $past(ss_i, 2)) |-> !miso_oe); // R10
endmodule

bind spi_port spi_port_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_act    (m_act),
    .busy     (sh_busy),
    .fault_hit(fault_hit),
    .sck_o    (sck_o),
    .mosi_o   (mosi_o),
    .sck_oe   (sck_oe),
    .mosi_oe  (mosi_oe),
    .miso_oe  (miso_oe),
    .ss_o     (ss_o),
    .ss_oe    (ss_oe),
    .ss_i     (ss_i)
);

// File: tb/test_spi_port.sv
module test_spi_port;
    import spi_port_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_i = 1'b1, miso_i;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe, irq;
    logic       invert = 1'b0;

    always #5 clk = ~clk;
    assign miso_i = invert ^ mosi_o;

    spi_port i_spi_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe), .irq(irq)
    );

    int         n_chk = 0, n_bad = 0;
    logic [7:0] mosi_q[$];
    logic [7:0] rx_q[$];
    logic       mon_on = 1'b0;
    int         mon_n = 0;
    logic [7:0] mon_bits = '0, mon_exp;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_rx(input string tag);
        logic [7:0] v, e;
        bus_read(REG_DATA, v);
        e = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hxx;
        check(tag, v, e);
    endtask

    task automatic wait_done();
        logic [7:0] v;
        int guard = 0;
        do begin
            bus_read(REG_STAT, v);
            guard++;
        end while (!v[STA_DONE] && guard < 5000);
    endtask

    task automatic first_edge(output int n);
        n = 0;
        while (!sck_o && n < 5000) begin
            @(posedge clk); #1;
            n++;
        end
    endtask

    // driver: queue what MOSI and the data register must show, then start
    task automatic run_master(input logic [7:0] tx, input int half, input string tag);
        int n;
        mosi_q.push_back(tx);
        rx_q.push_back(invert ? ~tx : tx);
        bus_write(REG_DATA, tx);
        first_edge(n);
        check({"R2 first SCK edge ", tag}, n, half);
        check({"R5 ss_o low in transfer ", tag}, ss_o, 1'b0);
        wait_done();
        read_rx({"R3 received byte ", tag});
    endtask

    task automatic slave_bits(input logic [7:0] tx, input int nb, output logic [7:0] seen);
        seen = '0;
        for (int k = 0; k < nb; k++) begin
            mosi_i = tx[7-k];
            idle(6);
            sck_i = 1'b1;
            seen = {seen[6:0], miso_o};
            idle(6);
            sck_i = 1'b0;
            idle(6);
        end
    endtask

    // monitor: collect MOSI on each rising SCK and compare whole bytes
    always @(posedge sck_o) begin
        if (mon_on) begin
            mon_bits = {mon_bits[6:0], mosi_o};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (mosi_q.size() == 0) check("R4 unexpected MOSI byte", mon_bits, 32'hffff);
                else begin
                    mon_exp = mosi_q.pop_front();
                    check("R3 MOSI serial byte", mon_bits, mon_exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v, seen;
        int n;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        bus_read(REG_CTRL, v); check("R1 ctrl", v, 0);
        bus_read(REG_BAUD, v); check("R1 baud", v, 0);
        bus_read(REG_STAT, v); check("R1 status", v, 0);
        bus_read(REG_DATA, v); check("R1 data", v, 0);
        bus_read(REG_DIR, v);  check("R1 dir", v, 0);
        check("R1 enables", {sck_oe, mosi_oe, miso_oe, ss_oe}, 0);
        check("R1 ss_o/irq", {ss_o, irq}, 2'b10);

        // master setup: half period (2+1)*2^1 = 6
        bus_write(REG_BAUD, 8'h21);
        bus_write(REG_DIR, 8'h0B);
        bus_write(REG_CTRL, 8'h03);
        check("R5 master enables", {sck_oe, mosi_oe, miso_oe, ss_oe}, 4'b1101);
        check("R5 ss_o idle high", ss_o, 1'b1);
        mon_on = 1'b1;
        run_master(8'hA5, 6, "A5");

        // fastest divider, inverted loopback
        bus_write(REG_BAUD, 8'h00);
        invert = 1'b1;
        run_master(8'h3C, 1, "3C");
        invert = 1'b0;

        // R4 write during transfer is ignored
        bus_write(REG_BAUD, 8'h21);
        mosi_q.push_back(8'h96);
        rx_q.push_back(8'h96);
        bus_write(REG_DATA, 8'h96);
        idle(10);
        bus_write(REG_DATA, 8'h0F);
        wait_done();
        read_rx("R4 received byte unchanged");
        idle(20);
        check("R4 no second transfer", {ss_o, sck_o}, 2'b10);

        // R6 done flag clearing and interrupt
        bus_write(REG_CTRL, 8'h07);
        mosi_q.push_back(8'h5A);
        bus_write(REG_DATA, 8'h5A);
        idle(110);
        check("R6 irq on done", irq, 1'b1);
        bus_read(REG_DATA, v); check("R6 data", v, 8'h5A);
        bus_read(REG_STAT, v); check("R6 flag kept without status read", v[STA_DONE], 1'b1);
        bus_read(REG_DATA, v);
        bus_read(REG_STAT, v); check("R6 flag cleared", v[STA_DONE], 1'b0);
        check("R6 irq cleared", irq, 1'b0);

        // R7 mode fault
        mon_on = 1'b0;
        bus_write(REG_DIR, 8'h07);
        bus_write(REG_DATA, 8'hFF);
        idle(20);
        ss_i = 1'b0;
        idle(4);
        check("R7 irq on fault", irq, 1'b1);
        check("R7 sck/mosi released", {sck_oe, mosi_oe}, 2'b00);
        check("R7 transfer aborted", {ss_o, sck_o}, 2'b10);
        bus_read(REG_CTRL, v); check("R7 ctrl cleared", v, 8'h04);
        bus_read(REG_DIR, v);  check("R7 dir cleared", v, 8'h00);
        ss_i = 1'b1;
        // R8 control write without status read keeps the flag
        bus_write(REG_CTRL, 8'h04);
        idle(2);
        check("R8 fault kept", irq, 1'b1);
        bus_read(REG_STAT, v); check("R7 status fault bit", v, 8'h10);
        bus_write(REG_CTRL, 8'h00);
        bus_read(REG_STAT, v); check("R8 fault cleared", v, 8'h00);
        check("R8 irq low", irq, 1'b0);

        // slave mode
        bus_write(REG_CTRL, 8'h01);
        bus_write(REG_DIR, 8'h04);
        bus_write(REG_DATA, 8'hC6);
        idle(20);
        check("R11 no SCK in slave", {sck_o, ss_o}, 2'b01);
        bus_read(REG_STAT, v); check("R11 no completion", v, 8'h00);
        check("R10 miso released while ss high", miso_oe, 1'b0);
        ss_i = 1'b0;
        idle(4);
        check("R10 miso driven while ss low", miso_oe, 1'b1);
        slave_bits(8'h3B, 8, seen);
        idle(4);
        ss_i = 1'b1;
        idle(4);
        check("R10 miso released after ss high", miso_oe, 1'b0);
        check("R10 miso byte", seen, 8'hC6);
        bus_read(REG_STAT, v); check("R9 done flag", v[STA_DONE], 1'b1);
        bus_read(REG_DATA, v); check("R9 slave received", v, 8'h3B);

        // R10 partial byte is discarded on ss high
        ss_i = 1'b0;
        idle(4);
        slave_bits(8'hE0, 3, seen);
        ss_i = 1'b1;
        idle(4);
        bus_read(REG_STAT, v); check("R10 partial gives no byte", v, 8'h00);
        ss_i = 1'b0;
        idle(4);
        slave_bits(8'h71, 8, seen);
        ss_i = 1'b1;
        idle(4);
        bus_read(REG_STAT, v); check("R10 done after restart", v[STA_DONE], 1'b1);
        bus_read(REG_DATA, v); check("R10 byte after counter reset", v, 8'h71);

        check("R3 all MOSI bytes seen", mosi_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule